// File: doc/BRIEF.md
# AXI Reset Behaviour Checker

This block is a synthesizable monitor that sits beside an AXI4, AXI3 or AXI-Lite port and watches how that port comes out of reset. It samples the active-low interface reset on every rising clock edge. It counts how many consecutive samples the reset stays low. When the reset returns high after too few low samples, it raises a sticky error. Separately, it looks at the five channel READY lines (write address, write data, write response, read address, read data) in the first clock cycle in which reset reads high. Any READY found high there sets a sticky flag for that channel alone.

The monitor runs on its own state and never uses the monitored reset as its own reset. Because of this, its flags survive the very reset that raised them. Its state is brought to a known value by a synchronous clear input, `err_clr`. At power-up the clear is held for two cycles. That clear also starts the measurement of the first reset pulse, so the power-up reset is checked like any other. The pins are plain control and status lines. Nothing flows through the block as a stream, so it has no valid/ready handshake of its own and never applies back-pressure.

Top module: `axi_reset_checker`

## Requirements
- R1: When `err_clr` is sampled high on two consecutive rising edges, `err_short_reset` and every bit of `err_ready_early` read 0 after the second of those edges.
- R2: If `aresetn_mon` is sampled low on fewer than `MIN_LOW_CYCLES` (default 16) consecutive edges and then sampled high at edge k, `err_short_reset` is 0 after edge k and 1 after edge k+1.
- R3: A low stretch of exactly `MIN_LOW_CYCLES` samples, or of any longer length (the count saturates), leaves `err_short_reset` at 0.
- R4: If READY of a channel is high at edge k (the first edge at which `aresetn_mon` reads high after a low stretch), that channel's bit of `err_ready_early` is 0 after edge k+1 and 1 after edge k+2, and no other bit changes. Bit order: 0 write address, 1 write data, 2 write response, 3 read address, 4 read data.
- R5: READY high while reset is low, or at any edge after edge k, sets no bit of `err_ready_early`.
- R6: Every flag, once set, stays set through later resets, including well-formed ones, until a clear.
- R7: A flag set in the same edge at which `err_clr` is sampled high ends up set: a new violation takes priority over the clear.
- R8: Low samples of `aresetn_mon` are counted from the last edge at which `err_clr` is sampled high onward. A reset that is already low during the clear is therefore measured, and that last clear edge counts as one low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, all sampling on its rising edge |
| aresetn_mon | input | 1 | Monitored active-low interface reset |
| awready | input | 1 | Write address channel READY |
| wready | input | 1 | Write data channel READY |
| bready | input | 1 | Write response channel READY |
| arready | input | 1 | Read address channel READY |
| rready | input | 1 | Read data channel READY |
| err_clr | input | 1 | Synchronous clear of flags and measurement state |
| err_short_reset | output | 1 | Sticky: a reset low stretch was shorter than the minimum |
| err_ready_early | output | 5 | Sticky per-channel: READY high in the first cycle after reset release |

## Verification
The clear and the pulse-width verdict can land on the same edge. The bench provokes this by releasing a 3-sample reset and asserting `err_clr` in exactly the cycle that the width error is registered. It then expects `err_short_reset` to read 1 after that edge and on the following one. A second overlap is the clear coinciding with a reset that is already low. In that case the bench checks that the power-up pulse is measured from the last clear edge, once with a length that just passes and once with a length that fails.

// File: rtl/arc_pkg.sv
package arc_pkg;

  // Number of AXI channels carrying a READY line watched by the checker.
  localparam int NUM_CH = 5;

  // Fixed channel-to-bit mapping of the per-channel flag vector.
  typedef enum logic [2:0] {
    CH_AW = 3'd0,
    CH_W  = 3'd1,
    CH_B  = 3'd2,
    CH_AR = 3'd3,
    CH_R  = 3'd4
  } ch_e;

  // Reset level and edges, all aligned to the registered sample.
  typedef struct packed {
    logic level;
    logic fell;
    logic rose;
  } rst_ev_t;

endpackage

// File: rtl/arc_edge_sampler.sv
module arc_edge_sampler
  import arc_pkg::*;
#(
  parameter int N = NUM_CH
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         rst_in,
  input  logic [N-1:0] rdy_in,
  output rst_ev_t      ev,
  output logic [N-1:0] rdy_s
);

  logic smp_q;
  logic prev_q;

  // Input registers: reset level and READY lines captured on the same edge.
  always_ff @(posedge clk) begin
    smp_q <= rst_in;
    rdy_s <= rdy_in;
  end

  // History register; a clear makes the next low sample read as a fall.
  always_ff @(posedge clk) begin
    if (clr) prev_q <= 1'b1;
    else     prev_q <= smp_q;
  end

  always_comb begin
    ev.level = smp_q;
    ev.fell  = ~smp_q & prev_q;
    ev.rose  = smp_q & ~prev_q;
  end

endmodule

// File: rtl/arc_width_meter.sv
module arc_width_meter
  import arc_pkg::*;
#(
  parameter int MIN_LOW = 16
) (
  input  logic    clk,
  input  logic    clr,
  input  rst_ev_t ev,
  output logic    short_hit
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_LOW);

  logic [CNT_W-1:0] cnt_q;

  // Saturating count of consecutive low samples.
  always_ff @(posedge clk) begin
    if (clr)
      cnt_q <= '0;
    else if (!ev.level) begin
      if (ev.fell)
        cnt_q <= CNT_W'(1);
      else if (cnt_q != LIMIT)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign short_hit = ev.rose && (cnt_q < LIMIT);

endmodule

// File: rtl/arc_release_window.sv
module arc_release_window
  import arc_pkg::*;
#(
  parameter int N = NUM_CH
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         rose,
  input  logic [N-1:0] rdy_s,
  output logic [N-1:0] hit
);

  logic first_q;

  // One-cycle window flag, registered from the release edge.
  always_ff @(posedge clk) begin
    if (clr) first_q <= 1'b0;
    else     first_q <= rose;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic rdy_q;
    always_ff @(posedge clk) rdy_q <= rdy_s[g];
    assign hit[g] = first_q & rdy_q;
  end

endmodule

// File: rtl/arc_sticky_flags.sv
module arc_sticky_flags #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] flags
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    // A set arriving with the clear wins.
    always_ff @(posedge clk) begin
      flags[g] <= (flags[g] & ~clr) | set[g];
    end
  end

endmodule

// File: rtl/axi_reset_checker.sv
module axi_reset_checker
  import arc_pkg::*;
#(
  parameter int MIN_LOW_CYCLES = 16
) (
  input  logic              clk,
  input  logic              aresetn_mon,
  input  logic              awready,
  input  logic              wready,
  input  logic              bready,
  input  logic              arready,
  input  logic              rready,
  input  logic              err_clr,
  output logic              err_short_reset,
  output logic [NUM_CH-1:0] err_ready_early
);

  localparam int FLAG_W = NUM_CH + 1;

  logic [NUM_CH-1:0] rdy_vec;
  logic [NUM_CH-1:0] rdy_s;
  logic [NUM_CH-1:0] rdy_hit;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flag_vec;
  rst_ev_t           ev;
  logic              short_hit;

  always_comb begin
    rdy_vec              = '0;
    rdy_vec[int'(CH_AW)] = awready;
    rdy_vec[int'(CH_W)]  = wready;
    rdy_vec[int'(CH_B)]  = bready;
    rdy_vec[int'(CH_AR)] = arready;
    rdy_vec[int'(CH_R)]  = rready;
  end

  arc_edge_sampler #(.N(NUM_CH)) u_smp (
    .clk    (clk),
    .clr    (err_clr),
    .rst_in (aresetn_mon),
    .rdy_in (rdy_vec),
    .ev     (ev),
    .rdy_s  (rdy_s)
  );

  arc_width_meter #(.MIN_LOW(MIN_LOW_CYCLES)) u_width (
    .clk       (clk),
    .clr       (err_clr),
    .ev        (ev),
    .short_hit (short_hit)
  );

  arc_release_window #(.N(NUM_CH)) u_win (
    .clk   (clk),
    .clr   (err_clr),
    .rose  (ev.rose),
    .rdy_s (rdy_s),
    .hit   (rdy_hit)
  );

  assign set_vec = {rdy_hit, short_hit};

  arc_sticky_flags #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .clr   (err_clr),
    .set   (set_vec),
    .flags (flag_vec)
  );

  assign err_short_reset = flag_vec[0];
  assign err_ready_early = flag_vec[FLAG_W-1:1];

endmodule

// File: rtl/axi_reset_checker_sva.sv
module axi_reset_checker_sva
  import arc_pkg::*;
(
  input logic              clk,
  input logic              aresetn_mon,
  input logic              awready,
  input logic              wready,
  input logic              bready,
  input logic              arready,
  input logic              rready,
  input logic              err_clr,
  input logic              err_short_reset,
  input logic [NUM_CH-1:0] err_ready_early
);

  logic       seen_clr = 1'b0;
  logic [2:0] arm_cnt  = 3'd0;
  logic       armed;
  logic [NUM_CH-1:0] rdy_vec;

  always_ff @(posedge clk) begin
    if (err_clr) seen_clr <= 1'b1;
    if (seen_clr && arm_cnt != 3'd7) arm_cnt <= arm_cnt + 3'd1;
  end
  assign armed = (arm_cnt >= 3'd5);

  assign rdy_vec = {rready, arready, bready, wready, awready};

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
    $past(err_clr) && $past(err_clr, 2) |-> (!err_short_reset && err_ready_early == '0));

  assert_short_timing_R2: assert property (@(posedge clk) disable iff (!armed)
    $rose(err_short_reset) |-> $past(aresetn_mon, 2) && !$past(aresetn_mon, 3));

  assert_short_sticky_R6: assert property (@(posedge clk) disable iff (!armed)
    $past(err_short_reset) && !$past(err_clr) |-> err_short_reset);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R4 and R5: a channel flag rises only for READY seen on the release edge.
    assert_ready_window_R4: assert property (@(posedge clk) disable iff (!armed)
      $rose(err_ready_early[g]) |->
        $past(rdy_vec[g], 3) && $past(aresetn_mon, 3) && !$past(aresetn_mon, 4));

    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!armed)
      $past(err_ready_early[g]) && !$past(err_clr) |-> err_ready_early[g]);
  end

endmodule

bind axi_reset_checker axi_reset_checker_sva u_sva (.*);

// File: tb/axi_reset_checker_tb.sv
module axi_reset_checker_tb;

  logic       clk = 1'b0;
  logic       aresetn_mon = 1'b0;
  logic       awready = 1'b0, wready = 1'b0, bready = 1'b0, arready = 1'b0, rready = 1'b0;
  logic       err_clr = 1'b0;
  logic       err_short_reset;
  logic [4:0] err_ready_early;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    string      tag;
    logic       s;
    logic [4:0] r;
  } item_t;

  item_t exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  axi_reset_checker u_dut (
    .clk             (clk),
    .aresetn_mon     (aresetn_mon),
    .awready         (awready),
    .wready          (wready),
    .bready          (bready),
    .arready         (arready),
    .rready          (rready),
    .err_clr         (err_clr),
    .err_short_reset (err_short_reset),
    .err_ready_early (err_ready_early)
  );

  // Driver: one call drives the inputs sampled by the next rising edge.
  task automatic cyc(input logic r, input logic [4:0] rd, input logic c);
    @(negedge clk);
    aresetn_mon = r;
    {rready, arready, bready, wready, awready} = rd;
    err_clr = c;
  endtask

  // Expectation for the state right after the edge that samples the last cyc.
  task automatic want(input string tag, input logic s, input logic [4:0] r);
    item_t it;
    it.tag = tag; it.s = s; it.r = r;
    exp_q.push_back(it);
  endtask

  task automatic low(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 5'h00, 1'b0);
  endtask

  task automatic clear2(input logic r);
    cyc(r, 5'h00, 1'b1);
    cyc(r, 5'h00, 1'b1);
  endtask

  // Monitor: compares after each rising edge once outputs have settled.
  always begin
    @(posedge clk);
    #5;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (err_short_reset !== it.s || err_ready_early !== it.r) begin
        n_bad++;
        $display("FAIL %s: got short=%b ready=%b, expected short=%b ready=%b",
                 it.tag, err_short_reset, err_ready_early, it.s, it.r);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1, R8: power-up clear while reset already low; 1 + 15 = 16 samples.
    clear2(1'b0);                 want("R1", 1'b0, 5'h00);
    low(15);
    cyc(1'b1, 5'h00, 1'b0);
    idle(3);                      want("R8", 1'b0, 5'h00);

    // R8: clear during low, then 1 + 4 = 5 samples -> too short.
    clear2(1'b0);
    low(4);
    cyc(1'b1, 5'h00, 1'b0);
    idle(3);                      want("R8", 1'b1, 5'h00);

    // R2: 15 low samples; exact latency of the width flag.
    clear2(1'b1);                 want("R1", 1'b0, 5'h00);
    low(15);
    cyc(1'b1, 5'h00, 1'b0);       want("R2", 1'b0, 5'h00);
    cyc(1'b1, 5'h00, 1'b0);       want("R2", 1'b1, 5'h00);

    // R3: exactly the minimum, then a long saturating stretch.
    clear2(1'b1);
    low(16);
    cyc(1'b1, 5'h00, 1'b0);
    idle(3);                      want("R3", 1'b0, 5'h00);
    low(40);
    cyc(1'b1, 5'h00, 1'b0);
    idle(3);                      want("R3", 1'b0, 5'h00);

    // R4: each channel in turn, with its exact latency.
    for (int ch = 0; ch < 5; ch++) begin
      clear2(1'b1);
      low(20);
      cyc(1'b1, 5'(1 << ch), 1'b0);
      cyc(1'b1, 5'h00, 1'b0);     want("R4", 1'b0, 5'h00);
      cyc(1'b1, 5'h00, 1'b0);     want("R4", 1'b0, 5'(1 << ch));
      idle(2);
    end

    // R5: READY high during reset and from the second high cycle on.
    clear2(1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 5'h1f, 1'b0);
    cyc(1'b1, 5'h00, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 5'h1f, 1'b0);
    cyc(1'b1, 5'h00, 1'b0);       want("R5", 1'b0, 5'h00);

    // R6: short pulse, then a good pulse with a READY fault, all sticky.
    clear2(1'b1);
    low(4);
    cyc(1'b1, 5'h00, 1'b0);
    idle(3);
    low(30);
    cyc(1'b1, 5'h04, 1'b0);
    idle(3);                      want("R6", 1'b1, 5'h04);
    low(30);
    cyc(1'b1, 5'h00, 1'b0);
    idle(3);                      want("R6", 1'b1, 5'h04);
    clear2(1'b1);                 want("R1", 1'b0, 5'h00);

    // R7: clear on the edge at which the width error is registered.
    low(3);
    cyc(1'b1, 5'h00, 1'b0);
    cyc(1'b1, 5'h00, 1'b1);       want("R7", 1'b1, 5'h00);
    cyc(1'b1, 5'h00, 1'b0);       want("R7", 1'b1, 5'h00);

    idle(3);
    @(posedge clk);
    #6;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule